// File: doc/BRIEF.md
# Macro Instruction Sequencer with Delay Slots

This block steps through a short macro program for a command-processor engine. Each accepted start pulse runs one macro. The sequencer keeps a byte program counter and reads 32-bit instruction words from an external word-addressed memory. It keeps a small register file whose entry 0 is tied to zero. It also holds a carry flag and a parameter read index. It issues one instruction per cycle while running.

The sequencer decodes only three things from each word: the operation class, the branch and exit controls, and the two source register indices. Everything else goes to external ALU and result-dispatch logic. That logic gets the instruction word and both source values. In the same cycle it returns a register writeback, a carry update and a parameter-fetch strobe, and the sequencer commits these at the clock edge.

Taken branches have a single delay slot, and a set annul bit removes it. The exit flag also has a delay slot. When the flag appears on an instruction that is itself in a slot, it is ignored. An illegal situation stops the macro and raises an error level. The error stays high until the next accepted start.

Top module: `macro_seq`

## Requirements
- R1: An accepted start (start high while busy is low) resets the macro state on the next edge. The program counter goes to 0, so imemAddr reads 0 and busy goes high. Register 1 takes firstParam and every other register reads 0. The carry flag clears, paramIndex becomes 1 and error clears.
- R2: The program counter is a byte address. An executed instruction that is not a branch, carries no exit flag and is not in a slot moves it up by 4, so imemAddr (pc divided by 4) goes to the next word on the next cycle.
- R3: Register 0 always reads as zero. A writeback that targets it is discarded.
- R4: Word bits [2:0] hold the operation class, and class 7 is a branch. A branch tests the register named by bits [13:11]. Bit 5 selects the condition: 0 means taken when that register is zero, and 1 means taken when it is non-zero. The target is the branch's own byte address plus the signed byte offset in bits [31:14].
- R5: A taken branch with bit 6 clear runs exactly one following instruction (the delay slot) and then continues at the target.
- R6: A taken branch with bit 6 set goes straight to the target and does not run the following instruction.
- R7: Bit 7 is the exit flag. When an instruction outside a delay slot carries it, one more instruction runs and then the macro stops. At that point done pulses high for exactly one cycle and busy falls together with it.
- R8: An exit flag on an instruction that runs inside a delay slot does not end the macro.
- R9: A branch that reaches a delay slot is not issued. The macro stops, done stays low, and error goes high and stays high until the next accepted start.
- R10: Fetching a word at or beyond progWords stops the macro with error and does not issue that word.
- R11: Operation class 6 is reserved. Fetching it stops the macro with error and does not issue it.
- R12: On an issued cycle the block commits three things at the edge: wbEn/wbReg/wbData writes the register, carryWe loads carryIn into the carry flag, and paramFetch increments paramIndex. The next instruction sees the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted only while idle |
| firstParam | input | 32 | First macro parameter, loaded into register 1 on start |
| progWords | input | 7 | Number of loaded program words |
| imemAddr | output | 6 | Instruction memory word address (pc / 4) |
| imemData | input | 32 | Instruction word read at imemAddr |
| issue | output | 1 | Current instruction is executed and its writeback will be committed |
| instWord | output | 32 | Current instruction word for the external ALU and dispatch |
| inDelaySlot | output | 1 | Current instruction occupies a delay slot |
| srcAVal | output | 32 | Value of the register named by bits [13:11] |
| srcBVal | output | 32 | Value of the register named by bits [16:14] |
| carryFlag | output | 1 | Current carry flag |
| paramIndex | output | 8 | Index of the next parameter to fetch |
| wbEn | input | 1 | Register writeback enable |
| wbReg | input | 3 | Writeback register index |
| wbData | input | 32 | Writeback data |
| carryWe | input | 1 | Carry flag write enable |
| carryIn | input | 1 | New carry flag value |
| paramFetch | input | 1 | Advance the parameter index |
| busy | output | 1 | A macro is running |
| done | output | 1 | One-cycle pulse when a macro stops normally |
| error | output | 1 | Macro stopped on an illegal condition; held until next start |

## Verification
Faults in the slot bookkeeping appear in the trace of issued word addresses. A lost slot flag runs a skipped word or drops a slot instruction. That shows up at imemAddr within one instruction of the branch or exit, and it also changes the instruction count and the cycle in which done rises. Register-file faults, such as a stale clear, a writable register 0 or a late commit, show up on srcAVal for the next instruction that reads the register. A wrong carry or parameter index is visible on carryFlag and paramIndex right after start and after a macro ends.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  // Operation class held in instruction bits [2:0].
  typedef enum logic [2:0] {
    CLS_ADDI   = 3'd0,
    CLS_CARRY  = 3'd1,
    CLS_PARAM  = 3'd2,
    CLS_GEN3   = 3'd3,
    CLS_GEN4   = 3'd4,
    CLS_GEN5   = 3'd5,
    CLS_RESV   = 3'd6,
    CLS_BRANCH = 3'd7
  } opClass_e;

  localparam int CLS_LSB   = 0;
  localparam int CLS_W     = 3;
  localparam int COND_BIT  = 5;
  localparam int ANNUL_BIT = 6;
  localparam int EXIT_BIT  = 7;
  localparam int SRCA_LSB  = 11;
  localparam int SRCB_LSB  = 14;
  localparam int OFF_LSB   = 14;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seqState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic clearAll;
    logic commit;
  } dpStrobe_t;

endpackage

// File: rtl/macro_seq_dp.sv
module macro_seq_dp
  import mseq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 8,
  parameter int PIDX_W   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpStrobe_t                   strobe,
  input  logic [DATA_W-1:0]           firstParam,
  input  logic [DATA_W-1:0]           instWord,
  input  logic                        wbEn,
  input  logic [$clog2(NUM_REGS)-1:0] wbReg,
  input  logic [DATA_W-1:0]           wbData,
  input  logic                        carryWe,
  input  logic                        carryIn,
  input  logic                        paramFetch,
  output logic [DATA_W-1:0]           srcAVal,
  output logic [DATA_W-1:0]           srcBVal,
  output logic                        carryFlag,
  output logic [PIDX_W-1:0]           paramIndex
);

  localparam int REG_IDX_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][DATA_W-1:0] regFile;
  logic [REG_IDX_W-1:0] srcAIdx;
  logic [REG_IDX_W-1:0] srcBIdx;

  assign srcAIdx = instWord[SRCA_LSB +: REG_IDX_W];
  assign srcBIdx = instWord[SRCB_LSB +: REG_IDX_W];

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    if (gi == 0) begin : g_zero
      assign regFile[gi] = '0;
    end else begin : g_live
      logic [DATA_W-1:0] regQ;
      logic              wrHit;
      assign wrHit = strobe.commit && wbEn && (wbReg == REG_IDX_W'(gi));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regQ <= '0;
        end else if (strobe.clearAll) begin
          regQ <= (gi == 1) ? firstParam : '0;
        end else if (wrHit) begin
          regQ <= wbData;
        end
      end
      assign regFile[gi] = regQ;
    end
  end

  assign srcAVal = regFile[srcAIdx];
  assign srcBVal = regFile[srcBIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      carryFlag <= 1'b0;
    end else if (strobe.clearAll) begin
      carryFlag <= 1'b0;
    end else if (strobe.commit && carryWe) begin
      carryFlag <= carryIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paramIndex <= '0;
    end else if (strobe.clearAll) begin
      paramIndex <= PIDX_W'(1);
    end else if (strobe.commit && paramFetch) begin
      paramIndex <= paramIndex + PIDX_W'(1);
    end
  end

endmodule

// File: rtl/macro_seq_ctrl.sv
module macro_seq_ctrl
  import mseq_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IADDR_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [IADDR_W:0]   progWords,
  input  logic [DATA_W-1:0]  instWord,
  input  logic [DATA_W-1:0]  srcAVal,
  output logic [IADDR_W-1:0] imemAddr,
  output logic               issue,
  output logic               inDelaySlot,
  output logic               busy,
  output logic               done,
  output logic               error,
  output dpStrobe_t          strobe
);

  // One spare word bit so a pc past the last memory word stays detectable.
  localparam int PC_W = IADDR_W + 3;

  seqState_e       stateQ;
  logic [PC_W-1:0] pcQ;
  logic [PC_W-1:0] slotTargetQ;
  logic            inSlotQ;
  logic            slotExitQ;
  logic            doneQ;
  logic            errorQ;

  opClass_e        cls;
  logic            running;
  logic            isBranch;
  logic            exitFlag;
  logic            annul;
  logic            condNz;
  logic            srcIsZero;
  logic            taken;
  logic            pcBeyond;
  logic            faultNow;
  logic            startAccept;
  logic [IADDR_W:0] wordIdx;
  logic [PC_W-1:0] offPc;
  logic [PC_W-1:0] pcNext;
  logic [PC_W-1:0] target;

  always_comb begin
    cls       = opClass_e'(instWord[CLS_LSB +: CLS_W]);
    running   = (stateQ == ST_RUN);
    isBranch  = (cls == CLS_BRANCH);
    exitFlag  = instWord[EXIT_BIT];
    annul     = instWord[ANNUL_BIT];
    condNz    = instWord[COND_BIT];
    srcIsZero = (srcAVal == '0);
    taken     = isBranch && (condNz ? !srcIsZero : srcIsZero);
    wordIdx   = pcQ[PC_W-1:2];
    pcBeyond  = (wordIdx >= progWords);
    faultNow  = running && (pcBeyond || (cls == CLS_RESV) || (isBranch && inSlotQ));
    offPc     = instWord[OFF_LSB +: PC_W];
    pcNext    = pcQ + PC_W'(4);
    target    = pcQ + offPc;
    startAccept = start && !running;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ      <= ST_IDLE;
      pcQ         <= '0;
      slotTargetQ <= '0;
      inSlotQ     <= 1'b0;
      slotExitQ   <= 1'b0;
      doneQ       <= 1'b0;
      errorQ      <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (startAccept) begin
        stateQ    <= ST_RUN;
        pcQ       <= '0;
        inSlotQ   <= 1'b0;
        slotExitQ <= 1'b0;
        errorQ    <= 1'b0;
      end else if (running) begin
        if (faultNow) begin
          stateQ  <= ST_IDLE;
          errorQ  <= 1'b1;
          inSlotQ <= 1'b0;
        end else if (inSlotQ) begin
          inSlotQ <= 1'b0;
          if (slotExitQ) begin
            stateQ <= ST_IDLE;
            doneQ  <= 1'b1;
          end else begin
            pcQ <= slotTargetQ;
          end
        end else if (taken && annul) begin
          pcQ <= target;
        end else if (taken) begin
          pcQ         <= pcNext;
          slotTargetQ <= target;
          inSlotQ     <= 1'b1;
          slotExitQ   <= 1'b0;
        end else if (exitFlag) begin
          pcQ       <= pcNext;
          inSlotQ   <= 1'b1;
          slotExitQ <= 1'b1;
        end else begin
          pcQ <= pcNext;
        end
      end
    end
  end

  assign imemAddr        = pcQ[IADDR_W+1:2];
  assign issue           = running && !faultNow;
  assign inDelaySlot     = inSlotQ;
  assign busy            = running;
  assign done            = doneQ;
  assign error           = errorQ;
  assign strobe.clearAll = startAccept;
  assign strobe.commit   = issue;

endmodule

// File: rtl/macro_seq.sv
module macro_seq
  import mseq_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IADDR_W  = 6,
  parameter int NUM_REGS = 8,
  parameter int PIDX_W   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [DATA_W-1:0]           firstParam,
  input  logic [IADDR_W:0]            progWords,
  output logic [IADDR_W-1:0]          imemAddr,
  input  logic [DATA_W-1:0]           imemData,
  output logic                        issue,
  output logic [DATA_W-1:0]           instWord,
  output logic                        inDelaySlot,
  output logic [DATA_W-1:0]           srcAVal,
  output logic [DATA_W-1:0]           srcBVal,
  output logic                        carryFlag,
  output logic [PIDX_W-1:0]           paramIndex,
  input  logic                        wbEn,
  input  logic [$clog2(NUM_REGS)-1:0] wbReg,
  input  logic [DATA_W-1:0]           wbData,
  input  logic                        carryWe,
  input  logic                        carryIn,
  input  logic                        paramFetch,
  output logic                        busy,
  output logic                        done,
  output logic                        error
);

  dpStrobe_t strobe;

  assign instWord = imemData;

  macro_seq_ctrl #(
    .DATA_W (DATA_W),
    .IADDR_W(IADDR_W)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .progWords  (progWords),
    .instWord   (imemData),
    .srcAVal    (srcAVal),
    .imemAddr   (imemAddr),
    .issue      (issue),
    .inDelaySlot(inDelaySlot),
    .busy       (busy),
    .done       (done),
    .error      (error),
    .strobe     (strobe)
  );

  macro_seq_dp #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS),
    .PIDX_W  (PIDX_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .firstParam(firstParam),
    .instWord  (imemData),
    .wbEn      (wbEn),
    .wbReg     (wbReg),
    .wbData    (wbData),
    .carryWe   (carryWe),
    .carryIn   (carryIn),
    .paramFetch(paramFetch),
    .srcAVal   (srcAVal),
    .srcBVal   (srcBVal),
    .carryFlag (carryFlag),
    .paramIndex(paramIndex)
  );

endmodule

// File: rtl/macro_seq_sva.sv
module macro_seq_sva #(
  parameter int DATA_W   = 32,
  parameter int IADDR_W  = 6,
  parameter int NUM_REGS = 8,
  parameter int PIDX_W   = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        start,
  input logic [DATA_W-1:0]           firstParam,
  input logic [IADDR_W:0]            progWords,
  input logic [IADDR_W-1:0]          imemAddr,
  input logic [DATA_W-1:0]           imemData,
  input logic                        issue,
  input logic [DATA_W-1:0]           instWord,
  input logic                        inDelaySlot,
  input logic [DATA_W-1:0]           srcAVal,
  input logic [DATA_W-1:0]           srcBVal,
  input logic                        carryFlag,
  input logic [PIDX_W-1:0]           paramIndex,
  input logic                        wbEn,
  input logic [$clog2(NUM_REGS)-1:0] wbReg,
  input logic [DATA_W-1:0]           wbData,
  input logic                        carryWe,
  input logic                        carryIn,
  input logic                        paramFetch,
  input logic                        busy,
  input logic                        done,
  input logic                        error
);

  AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && imemAddr == '0 && paramIndex == PIDX_W'(1) && !carryFlag && !error)); // R1

  AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (issue && !inDelaySlot && instWord[2:0] != 3'd7 && !instWord[7])
      |=> (busy && imemAddr == IADDR_W'($past(imemAddr) + 1'b1))); // R2

  AST_ZERO_REG: assert property (@(posedge clk) disable iff (!rstN)
    (busy && instWord[13:11] == 3'd0) |-> (srcAVal == '0)); // R3

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !error)); // R7

  AST_SLOT_BRANCH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && inDelaySlot && instWord[2:0] == 3'd7) |-> !issue); // R9

  AST_SLOT_BRANCH_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && inDelaySlot && instWord[2:0] == 3'd7) |=> (error && !busy && !done)); // R9

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (error && !start) |=> error); // R9

  AST_RESV_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && instWord[2:0] == 3'd6) |=> (error && !busy)); // R11

  AST_BEYOND_STOP: assert property (@(posedge clk) disable iff (!rstN)
    (busy && {1'b0, imemAddr} >= progWords) |-> !issue); // R10

endmodule

bind macro_seq macro_seq_sva #(
  .DATA_W  (DATA_W),
  .IADDR_W (IADDR_W),
  .NUM_REGS(NUM_REGS),
  .PIDX_W  (PIDX_W)
) sva_i (.*);

// File: tb/macro_seq_tb_top.sv
module macro_seq_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] firstParam = '0;
  logic [6:0]  progWords = '0;
  logic [5:0]  imemAddr;
  logic [31:0] imemData;
  logic        issue;
  logic [31:0] instWord;
  logic        inDelaySlot;
  logic [31:0] srcAVal;
  logic [31:0] srcBVal;
  logic        carryFlag;
  logic [7:0]  paramIndex;
  logic        wbEn;
  logic [2:0]  wbReg;
  logic [31:0] wbData;
  logic        carryWe;
  logic        carryIn;
  logic        paramFetch;
  logic        busy;
  logic        done;
  logic        error;

  logic [31:0] mem [64];

  int checks = 0;
  int fails = 0;
  int cycleCnt = 0;

  int          runCount;
  logic [15:0] runMask;
  int          doneCycles;
  logic        sawError;
  logic [31:0] srcAAt [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign imemData = mem[imemAddr];

  // Model of the external ALU / dispatch: class 0 adds a 15-bit immediate
  // (bits [31:17]) to source A into dst (bits [10:8]); class 1 loads carry
  // from bit 17; class 2 fetches a parameter.
  always_comb begin
    wbEn       = issue && (instWord[2:0] == 3'd0);
    wbReg      = instWord[10:8];
    wbData     = srcAVal + {17'b0, instWord[31:17]};
    carryWe    = issue && (instWord[2:0] == 3'd1);
    carryIn    = instWord[17];
    paramFetch = issue && (instWord[2:0] == 3'd2);
  end

  macro_seq dut_i (.*);

  function automatic logic [31:0] addi(input int dst, input int srcA, input int imm, input bit ex);
    return {15'(imm), 3'd0, 3'(srcA), 3'(dst), ex, 4'd0, 3'd0};
  endfunction

  function automatic logic [31:0] br(input int srcA, input bit nz, input bit ann, input int off, input bit ex);
    return {18'(off), 3'(srcA), 3'd0, ex, ann, nz, 2'd0, 3'd7};
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) mem[i] = addi(0, 0, 0, 1'b0);
  endtask

  task automatic runMacro(input logic [31:0] p, input int words);
    bit ended;
    progWords  = 7'(words);
    firstParam = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    runCount = 0;
    runMask = '0;
    doneCycles = 0;
    sawError = 1'b0;
    ended = 1'b0;
    for (int i = 0; i < 16; i++) srcAAt[i] = 32'hDEAD_BEEF;
    for (int c = 0; c < 80 && !ended; c++) begin
      if (issue) begin
        runMask[imemAddr[3:0]] = 1'b1;
        srcAAt[imemAddr[3:0]] = srcAVal;
        runCount++;
      end
      if (done) begin
        doneCycles++;
        ended = 1'b1;
      end
      if (error) begin
        sawError = 1'b1;
        ended = 1'b1;
      end
      @(negedge clk);
    end
    if (done) doneCycles++;
  endtask

  // {param[7:0], condNz, annul, count[3:0], mask[7:0]}
  localparam logic [21:0] VEC [6] = '{
    {8'd0, 1'b0, 1'b0, 4'd4, 8'h1B},
    {8'd0, 1'b0, 1'b1, 4'd3, 8'h19},
    {8'd5, 1'b0, 1'b0, 4'd5, 8'h1F},
    {8'd5, 1'b1, 1'b0, 4'd4, 8'h1B},
    {8'd5, 1'b1, 1'b1, 4'd3, 8'h19},
    {8'd0, 1'b1, 1'b1, 4'd5, 8'h1F}
  };

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycleCnt);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    clearMem();
    repeat (3) @(negedge clk);
    // Reset state
    chk("R1 reset busy", busy, 0);
    chk("R7 reset done", done, 0);
    chk("R9 reset error", error, 0);
    chk("R2 reset issue", issue, 0);
    rstN = 1'b1;
    @(negedge clk);

    // Table walk: branch condition, annul, exit slot (R4 R5 R6 R7)
    for (int v = 0; v < 6; v++) begin
      logic [21:0] e;
      e = VEC[v];
      clearMem();
      mem[0] = br(1, e[13], e[12], 12, 1'b0);
      mem[1] = addi(2, 2, 1, 1'b0);
      mem[2] = addi(2, 2, 2, 1'b0);
      mem[3] = addi(2, 2, 4, 1'b1);
      mem[4] = addi(2, 2, 8, 1'b0);
      mem[5] = addi(2, 2, 16, 1'b0);
      runMacro({24'd0, e[21:14]}, 6);
      chk("R5 R6 issued word mask", runMask, {8'd0, e[7:0]});
      chk("R4 issued count", runCount, e[11:8]);
      chk("R7 done one cycle", doneCycles, 1);
      chk("R7 busy low after stop", busy, 0);
    end

    // Register file, zero register and writeback (R1 R3 R12)
    clearMem();
    mem[0] = addi(0, 1, 3, 1'b0);
    mem[1] = addi(3, 0, 0, 1'b0);
    mem[2] = addi(2, 1, 1, 1'b0);
    mem[3] = addi(4, 2, 0, 1'b0);
    mem[4] = 32'h0002_0081;
    mem[5] = 32'h0000_0002;
    runMacro(32'h0000_1234, 6);
    chk("R1 r1 holds first param", srcAAt[0], 32'h1234);
    chk("R3 r0 write discarded", srcAAt[1], 0);
    chk("R12 writeback visible next", srcAAt[3], 32'h1235);
    chk("R12 carry loaded", carryFlag, 1);
    chk("R12 param index advanced", paramIndex, 2);
    chk("R2 word count", runCount, 6);

    // Restart clears state (R1)
    clearMem();
    mem[0] = addi(5, 2, 0, 1'b1);
    mem[1] = addi(5, 3, 0, 1'b0);
    runMacro(32'h0000_0077, 2);
    chk("R1 r2 cleared on start", srcAAt[0], 0);
    chk("R1 r3 cleared on start", srcAAt[1], 0);
    chk("R1 carry cleared", carryFlag, 0);
    chk("R1 param index one", paramIndex, 1);

    // Negative offset, annulled jumps (R4)
    clearMem();
    mem[0] = br(0, 1'b0, 1'b1, 12, 1'b0);
    mem[3] = br(0, 1'b0, 1'b1, -8, 1'b0);
    mem[1] = addi(2, 2, 1, 1'b1);
    mem[2] = addi(2, 2, 1, 1'b0);
    runMacro(32'h0, 8);
    chk("R4 backward target mask", runMask, 16'h000F);
    chk("R4 backward target count", runCount, 4);

    // Exit flag in a delay slot is ignored (R8)
    clearMem();
    mem[0] = br(0, 1'b0, 1'b0, 12, 1'b0);
    mem[1] = addi(2, 2, 1, 1'b1);
    mem[2] = addi(2, 2, 2, 1'b0);
    mem[3] = addi(2, 2, 4, 1'b1);
    mem[4] = addi(2, 2, 8, 1'b0);
    runMacro(32'h0, 8);
    chk("R8 slot exit ignored mask", runMask, 16'h001B);
    chk("R8 slot exit ignored done", doneCycles, 1);

    // Branch in a delay slot (R9)
    clearMem();
    mem[0] = br(0, 1'b0, 1'b0, 8, 1'b0);
    mem[1] = br(0, 1'b0, 1'b0, 8, 1'b0);
    runMacro(32'h0, 8);
    chk("R9 slot branch error", error, 1);
    chk("R9 slot branch not issued", runCount, 1);
    chk("R9 no done on error", doneCycles, 0);
    chk("R9 busy low", busy, 0);
    repeat (3) @(negedge clk);
    chk("R9 error held", error, 1);

    // Fetch past program end (R10)
    clearMem();
    mem[0] = addi(2, 2, 1, 1'b0);
    mem[1] = addi(2, 2, 1, 1'b0);
    runMacro(32'h0, 2);
    chk("R10 beyond end error", sawError, 1);
    chk("R10 beyond end count", runCount, 2);

    // Reserved class (R11)
    clearMem();
    mem[0] = addi(2, 2, 1, 1'b0);
    mem[1] = 32'h0000_0006;
    runMacro(32'h0, 8);
    chk("R11 reserved error", error, 1);
    chk("R11 reserved not issued", runCount, 1);

    // Start clears a held error (R1)
    clearMem();
    mem[0] = addi(2, 2, 1, 1'b1);
    runMacro(32'h0, 8);
    chk("R1 error cleared by start", error, 0);
    chk("R7 plain exit count", runCount, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule